// File: doc/BRIEF.md
# Serial Clock Divider with Bypass

This block derives the serial clock of a flash or SPI host from its source clock. It also produces two one-cycle enables, one for launching data and one for capturing it, which the transaction sequencer uses to shift and sample. A single 32-bit configuration word sets the division.

- In divided mode, the low byte gives the period count N. The next byte gives H, the count at which the serial clock falls, and the third byte gives L, the count at which it rises.
- Setting the top bit selects bypass, in which the source clock is passed straight through. A division factor of 1 can only be expressed this way. An encoder writes bypass for a factor of 1 and never writes N = 0.

A new word is adopted only when the internal count wraps, or at any edge while the clock is stopped. Stopping the clock parks the serial clock low with the count at zero.

The block also decodes a 2-bit source-frequency select into a value in MHz for reporting. It does not act on this value. All pins are plain control and status levels, and no data stream passes through the block, so it has no handshake.

Top module: `spi_sclk_divider`

## Requirements
- R1: In divided mode the count runs 0..N and wraps, so one serial clock period, and the spacing between two capture strobes, is N + 1 source cycles. N is cfg_word[7:0].
- R2: After the edge at which the count equals L (cfg_word[23:16]) the serial clock is high. After the edge at which it equals H (cfg_word[15:8]) it is low. At other counts it keeps its level. After a start it begins low, so in the first period it rises only at count L.
- R3: launch_stb is high for exactly the one source cycle that follows a falling serial-clock edge, and capture_stb for the one that follows a rising edge. In divided mode the two are never high together.
- R4: When the adopted word has bit 31 set and run is 1, sclk equals the source clock, and launch_stb and capture_stb are both high every cycle.
- R5: A cfg_word change while running is adopted only at the edge where the count equals N. The period in progress completes with the old settings.
- R6: With run at 0, the next edge drives sclk low, both strobes low and the count to 0, and they stay there. After run returns to 1, the first rising edge comes at edge number L + 1. In bypass mode with run at 0, sclk is low.
- R7: src_mhz decodes src_sel as 0 to 80, 1 to 120 and 2 to 160. The value 3 gives src_mhz = 0 with src_sel_bad = 1. The other values give src_sel_bad = 0.
- R8: A division factor of 1 is written as bit 31 = 1. In that case the N, H and L bytes are ignored and the output behaves as in R4.
- R9: H and L come from their own bytes and do not depend on N. Any H < L <= N gives a period of N + 1, and the low time spans counts H+1..L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = serial clock running, 0 = parked low |
| cfg_word | input | 32 | Division word: [31] bypass, [23:16] L, [15:8] H, [7:0] N |
| src_sel | input | 2 | Encoded source-frequency select |
| sclk | output | 1 | Serial clock level |
| launch_stb | output | 1 | One-cycle enable after a falling serial-clock edge |
| capture_stb | output | 1 | One-cycle enable after a rising serial-clock edge |
| src_mhz | output | 8 | Reported source frequency in MHz, 0 if invalid |
| src_sel_bad | output | 1 | src_sel holds the unused code |

## Verification
The assertions check several rules on every cycle:
- the count never passes N;
- a held word is never swapped mid-period;
- a stopped clock parks low at count zero;
- every launch strobe follows a falling level and every capture strobe a rising one, never both in divided mode.

Only the bench scenarios can show the rest:
- the exact waveform for each division factor;
- the near-50% duty split;
- the moment a changed word takes effect;
- that bypass passes both phases of the source clock with its field bytes ignored;
- the frequency decode.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  parameter int unsigned SCLK_FIELD_W = 8;
  parameter int unsigned SCLK_WORD_W  = 32;
  parameter int unsigned SCLK_BYP_BIT = 31;

  typedef struct packed {
    logic                    byp;
    logic [SCLK_FIELD_W-1:0] l;
    logic [SCLK_FIELD_W-1:0] h;
    logic [SCLK_FIELD_W-1:0] n;
  } sclk_cfg_t;

  function automatic sclk_cfg_t sclk_unpack(input logic [SCLK_WORD_W-1:0] w);
    sclk_cfg_t c;
    c.byp = w[SCLK_BYP_BIT];
    c.n   = w[SCLK_FIELD_W-1:0];
    c.h   = w[2*SCLK_FIELD_W-1:SCLK_FIELD_W];
    c.l   = w[3*SCLK_FIELD_W-1:2*SCLK_FIELD_W];
    return c;
  endfunction
endpackage

// File: rtl/spi_sclk_cfg_hold.sv
module spi_sclk_cfg_hold
  import spi_sclk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [SCLK_WORD_W-1:0] cfg_word,
  output sclk_cfg_t              cfg_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_act <= '0;
    else if (load) cfg_act <= sclk_unpack(cfg_word);
  end
endmodule

// File: rtl/spi_sclk_count.sv
module spi_sclk_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             byp,
  input  logic [CNT_W-1:0] n_lim,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = byp || (cnt == n_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || wrap) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_sclk_edges.sv
module spi_sclk_edges #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             byp,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] h_pt,
  input  logic [CNT_W-1:0] l_pt,
  output logic             sclk_q,
  output logic             launch_q,
  output logic             capture_q
);
  logic nxt;

  always_comb begin
    if (cnt == l_pt)      nxt = 1'b1;
    else if (cnt == h_pt) nxt = 1'b0;
    else                  nxt = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else if (!run || byp) begin
      sclk_q    <= 1'b0;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else begin
      sclk_q    <= nxt;
      launch_q  <= sclk_q & ~nxt;
      capture_q <= ~sclk_q & nxt;
    end
  end
endmodule

// File: rtl/spi_sclk_src_map.sv
module spi_sclk_src_map #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned MHZ_W  = 8,
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned BASE   = 80,
  parameter int unsigned STEP   = 40
) (
  input  logic [SEL_W-1:0] src_sel,
  output logic [MHZ_W-1:0] src_mhz,
  output logic             src_bad
);
  logic [N_SRC-1:0]             hit;
  logic [N_SRC-1:0][MHZ_W-1:0]  val;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = (src_sel == SEL_W'(i));
    assign val[i] = hit[i] ? MHZ_W'(BASE + STEP * i) : '0;
  end

  always_comb begin
    src_mhz = '0;
    for (int i = 0; i < N_SRC; i++) src_mhz = src_mhz | val[i];
  end

  assign src_bad = ~|hit;
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_sclk_pkg::*;
#(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned MHZ_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [SCLK_WORD_W-1:0] cfg_word,
  input  logic [SEL_W-1:0]       src_sel,
  output logic                   sclk,
  output logic                   launch_stb,
  output logic                   capture_stb,
  output logic [MHZ_W-1:0]       src_mhz,
  output logic                   src_sel_bad
);
  localparam int unsigned CNT_W = SCLK_FIELD_W;

  sclk_cfg_t        cfg_act;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             sclk_q, launch_q, capture_q;

  spi_sclk_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .load(!run || wrap),
    .cfg_word(cfg_word), .cfg_act(cfg_act)
  );

  spi_sclk_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .byp(cfg_act.byp),
    .n_lim(cfg_act.n), .cnt(cnt), .wrap(wrap)
  );

  spi_sclk_edges #(.CNT_W(CNT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .byp(cfg_act.byp),
    .cnt(cnt), .h_pt(cfg_act.h), .l_pt(cfg_act.l),
    .sclk_q(sclk_q), .launch_q(launch_q), .capture_q(capture_q)
  );

  spi_sclk_src_map #(.SEL_W(SEL_W), .MHZ_W(MHZ_W)) u_src (
    .src_sel(src_sel), .src_mhz(src_mhz), .src_bad(src_sel_bad)
  );

  // Bypass hands the source clock through, gated by run (R4, R8)
  assign sclk        = cfg_act.byp ? (clk & run) : sclk_q;
  assign launch_stb  = cfg_act.byp ? run : launch_q;
  assign capture_stb = cfg_act.byp ? run : capture_q;
endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk
  import spi_sclk_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run,
  input sclk_cfg_t               cfg_act,
  input logic [SCLK_FIELD_W-1:0] cnt,
  input logic                    sclk_q,
  input logic                    launch_q,
  input logic                    capture_q
);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cfg_act.n || cnt == '0);

  p_launch_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> (!sclk_q && $past(sclk_q)));

  p_capture_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_q |-> (sclk_q && !$past(sclk_q)));

  p_no_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_act.byp |-> !(launch_q && capture_q));

  p_hold_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg_act.byp && cnt != cfg_act.n) |=> $stable(cfg_act));

  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !sclk_q && !launch_q && !capture_q));
endmodule

bind spi_sclk_divider spi_sclk_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cfg_act(cfg_act), .cnt(cnt),
  .sclk_q(sclk_q), .launch_q(launch_q), .capture_q(capture_q)
);

// File: tb/spi_sclk_divider_bench.sv
module spi_sclk_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [1:0]  src_sel = '0;
  logic        sclk, launch_stb, capture_stb, src_sel_bad;
  logic [7:0]  src_mhz;

  int vec = 0;
  int bad = 0;

  always #4 clk = ~clk;

  spi_sclk_divider u_spi_sclk_divider (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_word(cfg_word),
    .src_sel(src_sel), .sclk(sclk), .launch_stb(launch_stb),
    .capture_stb(capture_stb), .src_mhz(src_mhz), .src_sel_bad(src_sel_bad)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] enc(input int d);
    if (d == 1) return 32'h8000_0000;
    return {8'h00, 8'(d - 1), 8'((d - 1) / 2), 8'(d - 1)};
  endfunction

  // Drive a word while parked, start, and compare each edge to the closed form.
  task automatic sweep(input logic [31:0] w, input int n, input int h, input int l,
                       input int edges, input string tag);
    run = 1'b0; cfg_word = w; step(); step();
    run = 1'b1;
    for (int k = 1; k <= edges; k++) begin
      int  p;
      bit  first;
      int  es, el, ec;
      step();
      p     = (k - 1) % (n + 1);
      first = (k - 1) < (n + 1);
      es = first ? int'(p >= l) : int'(p >= l || p < h);
      el = (!first && p == h) ? 1 : 0;
      ec = (p == l) ? 1 : 0;
      chk({tag, " sclk"}, int'(sclk), es);
      chk({tag, " launch"}, int'(launch_stb), el);
      chk({tag, " capture"}, int'(capture_stb), ec);
    end
    run = 1'b0; step();
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R6 reset sclk", int'(sclk), 0);
    chk("R6 reset launch", int'(launch_stb), 0);
    chk("R6 reset capture", int'(capture_stb), 0);

    // R1 R2 R3: sweep of division factors
    for (int d = 2; d <= 9; d++) begin
      sweep(enc(d), d - 1, (d - 1) / 2, d - 1, 3 * d, "R1 R2 R3 div");
    end

    // R9: independent H and L bytes
    sweep(32'h0003_0105, 5, 1, 3, 18, "R9 fields");
    sweep(32'h0005_0207, 7, 2, 5, 24, "R9 fields");

    // R5: change while running, divide 4 -> 3
    run = 1'b0; cfg_word = enc(4); step(); step();
    run = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      step();
      chk("R5 reload capture", int'(capture_stb),
          (k == 4 || k == 8 || k == 11 || k == 14) ? 1 : 0);
      if (k == 5) cfg_word = enc(3);
    end

    // R6: park mid-period, then restart from count 0
    run = 1'b0; cfg_word = enc(5); step(); step();
    run = 1'b1;
    for (int k = 1; k <= 7; k++) step();
    run = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      step();
      chk("R6 park sclk", int'(sclk), 0);
      chk("R6 park launch", int'(launch_stb), 0);
      chk("R6 park capture", int'(capture_stb), 0);
    end
    run = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step();
      chk("R6 restart capture", int'(capture_stb), (k == 5) ? 1 : 0);
      chk("R6 restart sclk", int'(sclk), (k == 5) ? 1 : 0);
    end
    run = 1'b0; step();

    // R4 R8: bypass with nonzero field bytes
    cfg_word = 32'h8003_0105; step(); step();
    run = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk("R4 R8 bypass high", int'(sclk), 1);
      chk("R4 bypass launch", int'(launch_stb), 1);
      chk("R4 bypass capture", int'(capture_stb), 1);
      @(negedge clk); #1;
      chk("R4 R8 bypass low", int'(sclk), 0);
    end
    run = 1'b0;
    @(posedge clk); #1;
    chk("R6 bypass parked", int'(sclk), 0);
    chk("R6 bypass strobe", int'(launch_stb), 0);
    @(negedge clk);

    // R8: encoder for factor 1 selects bypass, not N = 0
    chk("R8 encode", int'(enc(1)), int'(32'h8000_0000));

    // R7: source select decode
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      #1;
      chk("R7 mhz", int'(src_mhz), (s == 3) ? 0 : 80 + 40 * s);
      chk("R7 bad", int'(src_sel_bad), (s == 3) ? 1 : 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule